// File: doc/BRIEF.md
# Key Matrix Scanner and Multiplexed Digit Refresher

This block relieves a host processor of two repetitive chores. It walks a 64-key switch matrix, eight drive rows by eight sense columns, one row at a time, and filters out contact bounce. Each new key press becomes a 6-bit code in a small first-in first-out queue. It also refreshes a 16-digit seven-segment display on its own. A single slot counter does both jobs. The counter selects the keyboard row during the first eight slots. In every slot it also selects the digit whose pattern is driven on the segment pins.

The host reaches the block through a four-register port with a one-cycle read latency. The port pops key codes, reports the queue fill level and an overflow flag, and sets a display pointer. The pointer can step on its own after each access. Through the port the host also writes and reads the display patterns. Three static configuration pins choose the key entry policy (two-key lockout or N-key rollover), the scan line format (binary count or one line per slot) and the character entry style (fixed position or shift-in from the right).

Top module: `keymatrix_display_ctl`

## Requirements
- R1: The slot counter stays in each slot for SCAN_DIV cycles and steps 0,1,...,15,0. `scan_out` shows the slot as a binary value in bits 3:0 with all other bits zero when `cfg_decoded`=0, and as a single high bit at position slot when `cfg_decoded`=1.
- R2: `seg_out` always carries the display entry of the digit currently named on `scan_out`, and both change on the same clock edge.
- R3: `ret_in` is active high. It is sampled in the last cycle of slots 0 to 7, with the slot number as the row. A key is entered only after it is seen closed on two consecutive scans of its row, so a closure seen on a single scan makes no code.
- R4: A key code is {row[2:0], column[2:0]} in bits 5:0 with bits 7:6 zero. Reading register 0 returns the oldest code and removes it. Reading register 0 with an empty queue returns 0.
- R5: The queue holds 8 codes in arrival order. Reading register 1 returns the fill level in bits 3:0.
- R6: A code that arrives with 8 codes queued is dropped and sets status bit 7. Any write to register 1 clears that bit.
- R7: With `cfg_nkro`=0 (two-key lockout), a key pressed while another entered key is still held makes no code.
- R8: With `cfg_nkro`=1 (N-key rollover), every key is entered in the order detected. Keys that close together in one row are entered lowest column first, on successive scans.
- R9: A held key makes exactly one code. After it is released and pressed again, it makes a new code.
- R10: A write to register 2 sets the display pointer to bits 3:0 and the auto-step flag to bit 4. With `cfg_right_entry`=0, a write to register 3 stores the byte at the pointer. A read of register 3 returns the byte at the pointer. Either access advances the pointer when auto-step is set.
- R11: With `cfg_right_entry`=1, a write to register 3 moves every digit one place toward digit 0 and puts the new byte in digit 15. The pointer does not move.
- R12: After reset the queue is empty, the status reads 0 and all display entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nkro | input | 1 | 1: N-key rollover, 0: two-key lockout |
| cfg_decoded | input | 1 | 1: one-hot scan lines, 0: binary slot count |
| cfg_right_entry | input | 1 | 1: characters shift in from the right |
| ret_in | input | 8 | Matrix sense columns, high = closed |
| scan_out | output | 16 | Slot select lines |
| seg_out | output | 8 | Segment pattern of the selected digit |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 2 | Register select: 0 key, 1 status, 2 pointer, 3 display data |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after the strobe |

## Verification
Register reads return data one clock after the strobe, so the bench raises the strobe at a falling edge and samples at the next falling edge. A key code enters the queue one clock after the second closed sample of its row, which is at most about two scan frames after the press. The bench therefore waits three full frames before reading the fill level and draining codes against its scoreboard. Segment and scan outputs change on the same edge, and a display write reaches `seg_out` within two clocks. The refresh monitor starts a few cycles after the last write and compares every falling-edge sample of a whole frame.

// File: rtl/kmd_pkg.sv
package kmd_pkg;
  localparam int KEY_ROWS = 8;
  localparam int KEY_COLS = 8;
  localparam int ROW_W    = $clog2(KEY_ROWS);
  localparam int COL_W    = $clog2(KEY_COLS);
  localparam int CODE_W   = ROW_W + COL_W;
  localparam int DIGITS   = 16;
  localparam int DIG_W    = $clog2(DIGITS);
  localparam int SEG_W    = 8;
  localparam int HOST_DW  = 8;

  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_STAT = 2'd1,
    REG_PTR  = 2'd2,
    REG_DISP = 2'd3
  } host_reg_e;
endpackage

// File: rtl/kmd_scan_timer.sv
module kmd_scan_timer #(
  parameter int DIV    = 4,
  parameter int DIGITS = 16,
  parameter int DIG_W  = $clog2(DIGITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_decoded,
  output logic              slot_end,
  output logic [DIG_W-1:0]  digit,
  output logic [DIG_W-1:0]  digit_nxt,
  output logic [DIGITS-1:0] scan_out
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] dcnt;

  assign slot_end  = (dcnt == DIV_W'(DIV - 1));
  assign digit_nxt = !slot_end ? digit :
                     (digit == DIG_W'(DIGITS - 1)) ? '0 : digit + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt     <= '0;
      digit    <= '0;
      scan_out <= '0;
    end else begin
      dcnt     <= slot_end ? '0 : dcnt + 1'b1;
      digit    <= digit_nxt;
      scan_out <= cfg_decoded ? (DIGITS'(1) << digit_nxt) : DIGITS'(digit_nxt);
    end
  end

  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    (slot_end && digit != DIG_W'(DIGITS - 1)) |=> digit == $past(digit) + 1'b1);
  p_slot_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !slot_end |=> $stable(digit));
  p_decoded_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg_decoded && $past(cfg_decoded)) |-> $onehot(scan_out));
endmodule

// File: rtl/kmd_key_scan.sv
module kmd_key_scan #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int ROW_W = $clog2(ROWS),
  parameter int COL_W = $clog2(COLS),
  parameter int DIG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_nkro,
  input  logic                   slot_end,
  input  logic [DIG_W-1:0]       digit,
  input  logic [COLS-1:0]        ret_in,
  output logic                   push,
  output logic [ROW_W+COL_W-1:0] code
);
  logic [COLS-1:0]  prev_q [ROWS];
  logic [COLS-1:0]  held_q [ROWS];
  logic             kb_slot, any_held, found, accept;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] pick;
  logic [COLS-1:0]  cand;

  assign kb_slot = (digit < DIG_W'(ROWS));
  assign row     = digit[ROW_W-1:0];

  always_comb begin
    any_held = 1'b0;
    for (int r = 0; r < ROWS; r++) any_held = any_held | (|held_q[r]);
    cand  = ret_in & prev_q[row] & ~held_q[row];
    found = 1'b0;
    pick  = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (cand[c]) begin
        found = 1'b1;
        pick  = COL_W'(c);
      end
    end
    accept = slot_end && kb_slot && found && (cfg_nkro || !any_held);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        prev_q[r] <= '0;
        held_q[r] <= '0;
      end
      push <= 1'b0;
      code <= '0;
    end else begin
      push <= accept;
      if (accept) code <= {row, pick};
      if (slot_end && kb_slot) begin
        prev_q[row] <= ret_in;
        held_q[row] <= (held_q[row] & ret_in) | (accept ? (COLS'(1) << pick) : '0);
      end
    end
  end

  p_push_after_sample_r3: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(slot_end));
  p_push_single_r9: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);
endmodule

// File: rtl/kmd_code_fifo.sv
module kmd_code_fifo #(
  parameter int W     = 6,
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  input  logic             ovf_clr,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_pop, do_push;

  assign do_pop  = pop && (count != '0);
  assign do_push = push && ((count != CNT_W'(DEPTH)) || do_pop);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      if (push && !do_push) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && count == CNT_W'(DEPTH)) |=> (count == CNT_W'(DEPTH)) && ovf);
  p_pop_take_r4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count != '0) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/kmd_digit_ram.sv
module kmd_digit_ram #(
  parameter int DIGITS  = 16,
  parameter int DIG_W   = $clog2(DIGITS),
  parameter int SEG_W   = 8,
  parameter int HOST_DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_wr,
  input  logic               data_wr,
  input  logic               data_rd,
  input  logic [HOST_DW-1:0] wdata,
  input  logic               right_entry,
  input  logic [DIG_W-1:0]   digit_nxt,
  output logic [SEG_W-1:0]   rd_data,
  output logic [SEG_W-1:0]   seg_out
);
  logic [SEG_W-1:0] ram [DIGITS];
  logic [DIG_W-1:0] ptr;
  logic             autoinc;

  assign rd_data = ram[ptr];

  for (genvar d = 0; d < DIGITS; d++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        ram[d] <= '0;
      end else if (data_wr) begin
        if (right_entry) begin
          if (d == DIGITS - 1) ram[d] <= wdata[SEG_W-1:0];
          else                 ram[d] <= ram[(d + 1) % DIGITS];
        end else if (ptr == DIG_W'(d)) begin
          ram[d] <= wdata[SEG_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      autoinc <= 1'b0;
      seg_out <= '0;
    end else begin
      seg_out <= ram[digit_nxt];
      if (ptr_wr) begin
        ptr     <= wdata[DIG_W-1:0];
        autoinc <= wdata[DIG_W];
      end else if (autoinc && ((data_wr && !right_entry) || data_rd)) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  p_right_shift_r11: assert property (@(posedge clk) disable iff (rst)
    (data_wr && right_entry) |=>
      (ram[DIGITS-1] == $past(wdata[SEG_W-1:0])) && (ram[0] == $past(ram[1])));
  p_ptr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !right_entry && !ptr_wr && autoinc) |=> ptr == $past(ptr) + 1'b1);
  p_refresh_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(data_wr)) |-> seg_out == $past(ram[digit_nxt]));
endmodule

// File: rtl/keymatrix_display_ctl.sv
module keymatrix_display_ctl
  import kmd_pkg::*;
#(
  parameter int SCAN_DIV   = 256,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_nkro,
  input  logic               cfg_decoded,
  input  logic               cfg_right_entry,
  input  logic [KEY_COLS-1:0] ret_in,
  output logic [DIGITS-1:0]  scan_out,
  output logic [SEG_W-1:0]   seg_out,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [1:0]         host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  host_reg_e          reg_sel;
  logic               slot_end, push, fifo_ovf;
  logic [DIG_W-1:0]   digit, digit_nxt;
  logic [CODE_W-1:0]  code, fifo_dout;
  logic [CNT_W-1:0]   fifo_cnt;
  logic [SEG_W-1:0]   disp_rd;
  logic [HOST_DW-1:0] status;

  assign reg_sel = host_reg_e'(host_addr);
  assign status  = {fifo_ovf, {(HOST_DW - 1 - CNT_W){1'b0}}, fifo_cnt};

  kmd_scan_timer #(.DIV(SCAN_DIV), .DIGITS(DIGITS), .DIG_W(DIG_W)) u_timer (
    .clk(clk), .rst(rst), .cfg_decoded(cfg_decoded), .slot_end(slot_end),
    .digit(digit), .digit_nxt(digit_nxt), .scan_out(scan_out)
  );

  kmd_key_scan #(.ROWS(KEY_ROWS), .COLS(KEY_COLS), .ROW_W(ROW_W), .COL_W(COL_W),
                 .DIG_W(DIG_W)) u_keys (
    .clk(clk), .rst(rst), .cfg_nkro(cfg_nkro), .slot_end(slot_end), .digit(digit),
    .ret_in(ret_in), .push(push), .code(code)
  );

  kmd_code_fifo #(.W(CODE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(code),
    .pop(host_rd && reg_sel == REG_KEY),
    .ovf_clr(host_wr && reg_sel == REG_STAT),
    .dout(fifo_dout), .count(fifo_cnt), .ovf(fifo_ovf)
  );

  kmd_digit_ram #(.DIGITS(DIGITS), .DIG_W(DIG_W), .SEG_W(SEG_W), .HOST_DW(HOST_DW)) u_disp (
    .clk(clk), .rst(rst),
    .ptr_wr(host_wr && reg_sel == REG_PTR),
    .data_wr(host_wr && reg_sel == REG_DISP),
    .data_rd(host_rd && reg_sel == REG_DISP),
    .wdata(host_wdata), .right_entry(cfg_right_entry), .digit_nxt(digit_nxt),
    .rd_data(disp_rd), .seg_out(seg_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (reg_sel)
        REG_KEY:  host_rdata <= (fifo_cnt != '0) ? HOST_DW'(fifo_dout) : '0;
        REG_STAT: host_rdata <= status;
        REG_DISP: host_rdata <= HOST_DW'(disp_rd);
        default:  host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/tb_keymatrix_display_ctl.sv
module tb_keymatrix_display_ctl;
  localparam int DIV   = 4;
  localparam int FRAME = DIV * 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_nkro = 1'b1, cfg_decoded = 1'b0, cfg_right_entry = 1'b0;
  logic [7:0]  ret_in;
  logic [15:0] scan_out;
  logic [7:0]  seg_out;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;

  int checks = 0, failures = 0;
  logic [7:0] keymat [8];
  logic [7:0] disp_model [16];
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  keymatrix_display_ctl #(.SCAN_DIV(DIV), .FIFO_DEPTH(8)) dut (
    .clk(clk), .rst(rst), .cfg_nkro(cfg_nkro), .cfg_decoded(cfg_decoded),
    .cfg_right_entry(cfg_right_entry), .ret_in(ret_in), .scan_out(scan_out),
    .seg_out(seg_out), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic int slot_of(input logic [15:0] s, input logic dec);
    int v = -1;
    if (!dec) v = int'(s[3:0]);
    else for (int i = 0; i < 16; i++) if (s[i]) v = i;
    return v;
  endfunction

  always_comb begin
    int sl;
    sl = slot_of(scan_out, cfg_decoded);
    ret_in = 8'd0;
    if (sl >= 0 && sl < 8) ret_in = keymat[sl];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_frames(input int n);
    repeat (n * FRAME) @(negedge clk);
  endtask

  // driver: closes a key and records the code it is expected to make
  task automatic press(input int r, input int c, input bit expect_code);
    keymat[r][c] = 1'b1;
    if (expect_code) exp_q.push_back(8'((r << 3) | c));
  endtask

  // monitor: drains the queue and compares against the scoreboard
  task automatic drain(input string req);
    logic [7:0] st, cd;
    host_read(2'd1, st);
    chk({req, " fill level"}, int'(st[3:0]), exp_q.size());
    for (int i = 0; i < int'(st[3:0]); i++) begin
      host_read(2'd0, cd);
      if (exp_q.size() != 0) chk({req, " code order"}, int'(cd), int'(exp_q.pop_front()));
      else chk({req, " unexpected code"}, int'(cd), -1);
    end
    exp_q.delete();
  endtask

  task automatic check_scan(input string req);
    logic [15:0] prev;
    int last_t, bad, t, changes;
    bad = 0; changes = 0; last_t = -1;
    @(negedge clk);
    prev = scan_out;
    for (t = 0; t < FRAME + 20; t++) begin
      @(negedge clk);
      if (scan_out !== prev) begin
        if (cfg_decoded && $countones(scan_out) != 1) bad++;
        if (!cfg_decoded && scan_out[15:4] != 12'd0) bad++;
        if (slot_of(scan_out, cfg_decoded) != ((slot_of(prev, cfg_decoded) + 1) % 16)) bad++;
        if (last_t >= 0 && (t - last_t) != DIV) bad++;
        last_t = t;
        changes++;
        prev = scan_out;
      end
    end
    chk({req, " slot sequence errors"}, bad, 0);
    chk({req, " slot changes per frame"}, changes >= 16 ? 1 : 0, 1);
  endtask

  task automatic check_display(input string req);
    int bad = 0;
    repeat (3) @(negedge clk);
    for (int t = 0; t < FRAME + 8; t++) begin
      @(negedge clk);
      if (seg_out !== disp_model[slot_of(scan_out, cfg_decoded) & 15]) bad++;
    end
    chk({req, " refresh mismatches"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 8; i++) keymat[i] = 8'd0;
    for (int i = 0; i < 16; i++) disp_model[i] = 8'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R12: reset state
    host_read(2'd1, d); chk("R12 status after reset", d, 0);
    host_read(2'd0, d); chk("R12 R4 empty key read", d, 0);
    host_read(2'd3, d); chk("R12 display entry 0", d, 0);
    check_display("R12 blank display");

    // R1: both scan formats
    check_scan("R1 encoded");
    cfg_decoded = 1'b1;
    repeat (4) @(negedge clk);
    check_scan("R1 decoded");
    cfg_decoded = 1'b0;
    repeat (4) @(negedge clk);

    // R10: left entry with auto-step
    host_write(2'd2, 8'h10);
    for (int i = 0; i < 16; i++) begin
      disp_model[i] = 8'((i * 37 + 5) & 8'hff);
      host_write(2'd3, disp_model[i]);
    end
    host_write(2'd2, 8'h13);
    host_read(2'd3, d); chk("R10 read at pointer 3", d, disp_model[3]);
    host_read(2'd3, d); chk("R10 auto-step on read", d, disp_model[4]);
    host_write(2'd2, 8'h05);
    host_write(2'd3, 8'hAA);
    host_write(2'd3, 8'hAB);
    disp_model[5] = 8'hAB;
    host_read(2'd3, d); chk("R10 fixed pointer overwrite", d, 8'hAB);
    host_write(2'd2, 8'h06);
    host_read(2'd3, d); chk("R10 neighbour untouched", d, disp_model[6]);
    check_display("R2 encoded refresh");

    // R11: right entry
    cfg_right_entry = 1'b1;
    host_write(2'd3, 8'h11);
    host_write(2'd3, 8'h22);
    for (int i = 0; i < 14; i++) disp_model[i] = disp_model[i + 2];
    disp_model[14] = 8'h11;
    disp_model[15] = 8'h22;
    cfg_right_entry = 1'b0;
    host_write(2'd2, 8'h1E);
    host_read(2'd3, d); chk("R11 digit 14", d, 8'h11);
    host_read(2'd3, d); chk("R11 digit 15", d, 8'h22);
    cfg_decoded = 1'b1;
    check_display("R2 R11 decoded refresh");
    cfg_decoded = 1'b0;
    repeat (4) @(negedge clk);

    // R3: single-scan closure is filtered
    cfg_nkro = 1'b1;
    do @(negedge clk); while (scan_out != 16'd2);
    keymat[2][5] = 1'b1;
    do @(negedge clk); while (scan_out != 16'd3);
    keymat[2][5] = 1'b0;
    wait_frames(3);
    host_read(2'd1, d); chk("R3 bounce makes no code", d, 0);

    // R9 R4: one code per press, new code on re-press
    press(2, 5, 1);
    wait_frames(5);
    keymat[2][5] = 1'b0;
    wait_frames(3);
    press(2, 5, 1);
    wait_frames(3);
    keymat[2][5] = 1'b0;
    wait_frames(3);
    drain("R9 R4");

    // R8: rollover order across rows and within one row
    press(6, 1, 1);
    wait_frames(3);
    press(1, 7, 1);
    wait_frames(3);
    press(4, 2, 1);
    press(4, 6, 1);
    wait_frames(4);
    drain("R8 R5");
    for (int i = 0; i < 8; i++) keymat[i] = 8'd0;
    wait_frames(3);

    // R7: two-key lockout
    cfg_nkro = 1'b0;
    press(0, 0, 1);
    wait_frames(3);
    press(7, 7, 0);
    wait_frames(3);
    drain("R7");
    keymat[7][7] = 1'b0;
    wait_frames(3);
    keymat[0][0] = 1'b0;
    wait_frames(3);
    host_read(2'd1, d); chk("R7 nothing after release", d, 0);

    // R6: overflow
    cfg_nkro = 1'b1;
    for (int k = 0; k < 9; k++) begin
      press(k % 8, (k * 3 + 1) % 8 + (k / 8) * 0, k < 8);
      if (k == 8) keymat[3][0] = 1'b1;
      wait_frames(3);
    end
    host_read(2'd1, d); chk("R6 status full with overflow", d, 8'h88);
    drain("R6 R5");
    host_read(2'd1, d); chk("R6 flag kept until cleared", d, 8'h80);
    host_write(2'd1, 8'h00);
    host_read(2'd1, d); chk("R6 flag cleared", d, 0);
    for (int i = 0; i < 8; i++) keymat[i] = 8'd0;
    wait_frames(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule